// File: doc/BRIEF.md
# Timed Transition Delay Timer

This block is a hardware timed transition for a Petri-net controller. A trigger arms the timer. The timer then measures a fixed delay in whole time-base units and raises its output when the delay is over. A stop input halts the measurement and returns the timer to idle. Stop can arrive either while the timer is counting or after its output has risen.

The delay is built in two stages. A prescaler divides the system clock by `PRE_DIV` and produces a single-cycle time-base enable. With a 15 Hz clock and the default ratio of 15, that enable marks one-second units. A modulo-`DELAY_SECS` unit counter follows the prescaler, with a default of 20 units. A run state sits between trigger and counter, and time-base ticks reach the counter only while that state is armed. All state is on one clock, and the time base is an enable, not a derived clock.

Top module: `delay_transition_timer`

## Requirements
- R1: After reset (`rst_n` low, synchronous), `fire_o` and `base_tick_o` are both 0.
- R2: Once armed, `base_tick_o` is a single-cycle pulse that repeats every `PRE_DIV` clock cycles. Call the edge that arms the timer edge A. The first pulse is visible after edge A+`PRE_DIV`-1, and no pulse is visible after edges A+`PRE_DIV`-2 or A+`PRE_DIV`.
- R3: While the timer is idle, `trig_i` sampled high at an edge (with `stop_i` low) arms the timer. `fire_o` first reads 1 after edge A+`PRE_DIV`*`DELAY_SECS`.
- R4: Once high, `fire_o` stays high until `stop_i` is sampled. No `base_tick_o` pulse occurs while `fire_o` is high, so the unit count does not wrap.
- R5: When `stop_i` is sampled high, `fire_o` and `base_tick_o` read 0 after that edge. A later trigger then measures the full delay again.
- R6: A stop during counting prevents `fire_o` from rising. A later trigger measures the full delay from its own arming edge.
- R7: A trigger that arrives while the timer is counting is ignored. `fire_o` still rises at the time set by the first arming edge.
- R8: If `stop_i` and `trig_i` are high in the same cycle, stop wins and the timer is idle afterwards, so no `base_tick_o` pulses follow.
- R9: While idle with no trigger, no `base_tick_o` pulse occurs and `fire_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Arms the timer when sampled high while idle |
| stop_i | input | 1 | Halts counting and clears the timer to idle |
| fire_o | output | 1 | High once the delay has elapsed, held until stop |
| base_tick_o | output | 1 | Single-cycle time-base enable, active only while counting |

## Verification
The first pattern is a clean trigger pulse. It sets the exact latency and the spacing of the prescaler pulses, which separates an off-by-one in either stage from a correct design. A stop during counting, followed by a re-trigger, shows whether both counters are really cleared rather than only paused. A stop after firing shows that the held output clears. A second trigger in the middle of counting tells an ignored trigger from one that restarts the delay. A trigger coinciding with stop checks the priority between them, and an idle stretch checks that nothing runs without a trigger.

// File: rtl/dtt_pkg.sv
// Shared types for the timed-transition delay timer.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package dtt_pkg;

    // Phase of the timed transition: waiting for a token, timing it, delay elapsed.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_FIRED = 2'd2
    } dtt_phase_t;

endpackage

// File: rtl/dtt_prescale.sv
// Prescaler: divides the clock by PRE_DIV, producing a one-cycle enable.
// Assumes: PRE_DIV >= 2. The count is held at zero while en is low, so the
// first pulse after enabling is exactly PRE_DIV cycles later.
module dtt_prescale #(
    parameter int unsigned PRE_DIV = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] pcnt;

    // Phase counter: wraps from the last value back to zero instead of stepping on.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pcnt <= '0;
        end else if (pcnt == P_LAST) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // Pulse output: high during the last phase of each division period.
    always_comb begin
        tick = en && (pcnt == P_LAST);
    end
endmodule

// File: rtl/dtt_seconds.sv
// Modulo-N unit counter: counts time-base ticks and flags the Nth one.
// Assumes: NUNITS >= 1, and ticks are single-cycle enables.
module dtt_seconds #(
    parameter int unsigned NUNITS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int unsigned SW = (NUNITS > 1) ? $clog2(NUNITS) : 1;
    localparam logic [SW-1:0] S_LAST = SW'(NUNITS - 1);

    logic [SW-1:0] scnt;

    // Unit count: clears on request, wraps modulo NUNITS on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            scnt <= '0;
        end else if (tick) begin
            if (scnt == S_LAST) begin
                scnt <= '0;
            end else begin
                scnt <= scnt + 1'b1;
            end
        end
    end

    // Terminal flag: the tick that completes the last unit.
    always_comb begin
        done = tick && (scnt == S_LAST);
    end
endmodule

// File: rtl/dtt_ctrl.sv
// Run control: arms on a trigger, enters the fired phase on completion,
// and returns to idle on stop, which takes priority over everything.
// Assumes: trig and stop are synchronous to clk.
module dtt_ctrl
    import dtt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic stop,
    input  logic done,
    output logic active,
    output logic fired
);
    dtt_phase_t phase, phase_nx;

    // Next phase: stop wins, triggers count only when idle.
    always_comb begin
        phase_nx = phase;
        if (stop) begin
            phase_nx = PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:  if (trig) phase_nx = PH_COUNT;
                PH_COUNT: if (done) phase_nx = PH_FIRED;
                PH_FIRED: phase_nx = PH_FIRED;
                default:  phase_nx = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nx;
        end
    end

    // Decoded outputs from the registered phase.
    always_comb begin
        active = (phase == PH_COUNT);
        fired  = (phase == PH_FIRED);
    end
endmodule

// File: rtl/delay_transition_timer.sv
// Timed transition: after a trigger, waits PRE_DIV*DELAY_SECS clock cycles,
// then holds fire_o high until stop. Stop also clears all timing state.
// Assumes: one clock domain, synchronous active-low reset, PRE_DIV >= 2,
// DELAY_SECS >= 1.
module delay_transition_timer #(
    parameter int unsigned PRE_DIV    = 15,
    parameter int unsigned DELAY_SECS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic stop_i,
    output logic fire_o,
    output logic base_tick_o
);
    logic active;
    logic fired;
    logic tick;
    logic done;
    logic units_clr;

    dtt_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig_i),
        .stop   (stop_i),
        .done   (done),
        .active (active),
        .fired  (fired)
    );

    dtt_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .tick  (tick)
    );

    // Unit counter clear: any time the timer is not counting.
    always_comb begin
        units_clr = stop_i || !active;
    end

    dtt_seconds #(.NUNITS(DELAY_SECS)) u_units (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (units_clr),
        .tick  (tick),
        .done  (done)
    );

    // Port drive.
    always_comb begin
        fire_o      = fired;
        base_tick_o = tick;
    end
endmodule

// File: rtl/dtt_checker.sv
// Property checker for delay_transition_timer, attached through bind.
// Assumes: the same clock and synchronous active-low reset as the design.
module dtt_checker (
    input logic clk,
    input logic rst_n,
    input logic trig_i,
    input logic stop_i,
    input logic fire_o,
    input logic base_tick_o
);
    // R2: the time base is a single-cycle pulse.
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick_o |=> !base_tick_o);

    // R3: the output only rises on completion of a time-base unit.
    p_fire_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire_o) |-> $past(base_tick_o));

    // R4: the output holds until stop.
    p_fire_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !stop_i) |=> fire_o);

    // R4: no counting while fired.
    p_no_tick_fired_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> !base_tick_o);

    // R5: stop clears output and time base; also covers R8 (stop beats trigger).
    p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!fire_o && !base_tick_o));

    // R8: simultaneous trigger and stop leave the timer idle.
    p_stop_beats_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && trig_i) |=> !base_tick_o);
endmodule

bind delay_transition_timer dtt_checker u_dtt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .stop_i      (stop_i),
    .fire_o      (fire_o),
    .base_tick_o (base_tick_o)
);

// File: tb/delay_transition_timer_test.sv
module delay_transition_timer_test;
    localparam int unsigned PRE_DIV    = 15;
    localparam int unsigned DELAY_SECS = 20;
    localparam int unsigned LAT        = PRE_DIV * DELAY_SECS;

    typedef struct {
        int unsigned at;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_i = 1'b0;
    logic stop_i = 1'b0;
    logic fire_o;
    logic base_tick_o;

    int unsigned cyc = 0;
    int unsigned tick_seen = 0;
    int total = 0;
    int bad = 0;
    bit  fire_prev = 1'b0;
    bit  finished = 1'b0;
    exp_t sb_q[$];

    delay_transition_timer #(.PRE_DIV(PRE_DIV), .DELAY_SECS(DELAY_SECS)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_i),
        .stop_i      (stop_i),
        .fire_o      (fire_o),
        .base_tick_o (base_tick_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: samples 1 ns after each edge; pops expected fire times on a rise.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (base_tick_o) tick_seen++;
            if (fire_o && !fire_prev) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R6 unexpected fire", int'(cyc), 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(cyc == e.at, e.tag, int'(cyc), int'(e.at));
                end
            end
            fire_prev = fire_o;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: one-cycle trigger; returns the arming edge number.
    task automatic arm(output int unsigned a);
        @(negedge clk);
        trig_i = 1'b1;
        @(posedge clk);
        #1;
        a = cyc;
        @(negedge clk);
        trig_i = 1'b0;
    endtask

    task automatic pulse_stop(input bit with_trig);
        @(negedge clk);
        stop_i = 1'b1;
        trig_i = with_trig;
        @(posedge clk);
        #1;
        @(negedge clk);
        stop_i = 1'b0;
        trig_i = 1'b0;
    endtask

    task automatic wait_sb();
        for (int i = 0; i < int'(LAT) + 40; i++) begin
            if (sb_q.size() == 0) break;
            step(1);
        end
        check(sb_q.size() == 0, "R3 fire never seen", sb_q.size(), 0);
        sb_q.delete();
    endtask

    task automatic goto_cyc(input int unsigned c);
        while (cyc < c) step(1);
    endtask

    initial begin
        int unsigned a;
        int unsigned t0;
        step(3);
        check(fire_o == 1'b0, "R1 fire after reset", fire_o, 0);
        check(base_tick_o == 1'b0, "R1 tick after reset", base_tick_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: idle stretch
        t0 = tick_seen;
        step(60);
        check(tick_seen == t0, "R9 idle ticks", tick_seen - t0, 0);
        check(fire_o == 1'b0, "R9 idle fire", fire_o, 0);

        // R2/R3: clean trigger
        arm(a);
        sb_q.push_back('{a + LAT, "R3 fire latency"});
        goto_cyc(a + PRE_DIV - 2);
        check(base_tick_o == 1'b0, "R2 tick early", base_tick_o, 0);
        step(1);
        check(base_tick_o == 1'b1, "R2 first tick", base_tick_o, 1);
        step(1);
        check(base_tick_o == 1'b0, "R2 tick width", base_tick_o, 0);
        goto_cyc(a + 2 * PRE_DIV - 1);
        check(base_tick_o == 1'b1, "R2 second tick", base_tick_o, 1);
        wait_sb();

        // R4: hold
        t0 = tick_seen;
        step(3 * PRE_DIV);
        check(fire_o == 1'b1, "R4 fire held", fire_o, 1);
        check(tick_seen == t0, "R4 no ticks while fired", tick_seen - t0, 0);

        // R5: stop after firing, then full delay again
        pulse_stop(1'b0);
        check(fire_o == 1'b0, "R5 fire cleared", fire_o, 0);
        arm(a);
        sb_q.push_back('{a + LAT, "R5 delay after stop"});
        wait_sb();
        pulse_stop(1'b0);

        // R6: stop mid-count
        arm(a);
        step(150);
        pulse_stop(1'b0);
        t0 = tick_seen;
        step(int'(LAT) + 30);
        check(fire_o == 1'b0, "R6 no fire after stop", fire_o, 0);
        check(tick_seen == t0, "R6 no ticks after stop", tick_seen - t0, 0);
        arm(a);
        sb_q.push_back('{a + LAT, "R6 full delay after re-trigger"});
        wait_sb();
        pulse_stop(1'b0);

        // R7: second trigger ignored
        arm(a);
        sb_q.push_back('{a + LAT, "R7 retrigger ignored"});
        step(100);
        arm(t0);
        wait_sb();
        pulse_stop(1'b0);

        // R8: stop and trigger together while counting
        arm(a);
        step(50);
        pulse_stop(1'b1);
        t0 = tick_seen;
        step(3 * PRE_DIV);
        check(tick_seen == t0, "R8 stop beats trigger", tick_seen - t0, 0);
        check(fire_o == 1'b0, "R8 fire low", fire_o, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule